// File: doc/BRIEF.md
# Dual-LFSR Keystream Byte Generator

This block turns a 40-bit seed into a repeatable stream of pseudo-random bytes. A narrow 17-bit shift register and a wide 25-bit shift register step together, one bit per clock. Each register's feedback bit is gathered into its own byte. After eight steps the two bytes are conditionally complemented according to a mode, then added with a carry that is kept from one byte to the next.

A client pulses `load_i` with a seed and a mode, then pulses `start_i`. Bytes then leave on a valid/ready output. While the consumer holds ready low, the generator freezes. A new load abandons the current stream and clears the carry, so the same seed and mode always reproduce the same bytes.

Top module: `keystream_gen`

## Requirements
- R1: After reset, `valid_o` is 0 and stays 0 until a seed has been loaded and generation started.
- R2: On load, the narrow register takes {1, seed[15:8], seed[7:0]}; bit 16 is forced to 1. On each step it shifts right and the XOR of its bits 0 and 14 enters bit 16.
- R3: On load, the wide register takes {seed[39:32], seed[31:24], seed[23:19], 1, seed[18:16]}; bit 3 is forced to 1. On each step it shifts right and the XOR of its bits 0, 3, 4 and 14 enters bit 24.
- R4: Each byte holds the feedback bits of eight consecutive steps, with the first bit in bit 0. With ready held high, the first byte is valid 8 clock edges after the edge that samples `start_i`.
- R5: The mode is captured at load. Mode 2'b00 complements neither byte. 2'b01 complements the wide register's byte. 2'b10 complements the narrow register's byte. 2'b11 behaves as 2'b00.
- R6: The output byte is the low 8 bits of narrow + wide + carry. The carry out of each sum is the carry in of the next sum. The carry is 0 for the first byte after a load.
- R7: No stepping happens between a load and the next `start_i`. When load and start arrive in the same cycle, load wins.
- R8: While `valid_o` is 1 and `ready_i` is 0, `byte_o` is held and both registers stop. No byte is lost or skipped.
- R9: A load clears a pending `valid_o` on the next cycle, and the old stream is never delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Seed load strobe |
| seed_i | input | 40 | Seed, five bytes |
| mode_i | input | 2 | Complement mode, captured with the seed |
| start_i | input | 1 | Begins generation after a load |
| ready_i | input | 1 | Consumer accepts the byte |
| valid_o | output | 1 | Byte available |
| byte_o | output | 8 | Keystream byte |

## Verification
The first byte is due on the eighth rising edge after the edge that samples `start_i`. The bench checks `valid_o` low one negative edge before that and high at it. Later bytes are expected whenever `valid_o` and `ready_i` are both high at a negative edge, which is half a cycle before the transfer edge, so each comparison sees settled values. A load is followed on the next edge by `valid_o` low, and the bench checks this at the following negative edge. During long stalls, the byte on offer is compared against the head of the scoreboard queue on several successive cycles.

// File: rtl/ksg_pkg.sv
package ksg_pkg;
  localparam int SEED_W = 40;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    MODE_PLAIN      = 2'b00,
    MODE_INV_WIDE   = 2'b01,
    MODE_INV_NARROW = 2'b10,
    MODE_PLAIN_ALT  = 2'b11
  } ks_mode_e;
endpackage

// File: rtl/ksg_lfsr.sv
module ksg_lfsr #(
  parameter int          W       = 17,
  parameter logic [W-1:0] TAPS   = '0,
  parameter int          ONE_POS = 16,
  parameter int          BYTE_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [W-1:0]      seed_i,
  input  logic              adv_i,
  output logic [BYTE_W-1:0] col_nxt_o
);
  logic [W-1:0]      q_q, q_d;
  logic [BYTE_W-1:0] col_q, col_d;
  logic              fb;
  logic              en;

  assign fb        = ^(q_q & TAPS);
  assign en        = load_i | adv_i;
  assign col_nxt_o = {fb, col_q[BYTE_W-1:1]};

  always_comb begin
    q_d   = q_q;
    col_d = col_q;
    if (load_i) begin
      q_d   = seed_i;
      col_d = '0;
    end else if (adv_i) begin
      q_d   = {fb, q_q[W-1:1]};
      col_d = col_nxt_o;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q   <= '0;
      col_q <= '0;
    end else if (en) begin
      q_q   <= q_d;
      col_q <= col_d;
    end
  end

  // R2 / R3: the forced seed bit is present after every load
  p_forced_one_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> q_q[ONE_POS]);

  // R8: without a step or load the register keeps its contents
  p_freeze_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv_i) |=> $stable(q_q));
endmodule

// File: rtl/ksg_sum.sv
module ksg_sum #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              fire_i,
  input  logic [BYTE_W-1:0] narrow_i,
  input  logic [BYTE_W-1:0] wide_i,
  input  logic              inv_narrow_i,
  input  logic              inv_wide_i,
  output logic [BYTE_W-1:0] byte_o
);
  logic [BYTE_W-1:0] a, b;
  logic [BYTE_W:0]   sum_w;
  logic              carry_q, carry_d;
  logic [BYTE_W-1:0] byte_q, byte_d;

  assign a      = narrow_i ^ {BYTE_W{inv_narrow_i}};
  assign b      = wide_i   ^ {BYTE_W{inv_wide_i}};
  assign sum_w  = {1'b0, a} + {1'b0, b} + (BYTE_W+1)'(carry_q);
  assign byte_o = byte_q;

  always_comb begin
    carry_d = carry_q;
    byte_d  = byte_q;
    if (clr_i) begin
      carry_d = 1'b0;
    end else if (fire_i) begin
      carry_d = sum_w[BYTE_W];
      byte_d  = sum_w[BYTE_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      carry_q <= 1'b0;
      byte_q  <= '0;
    end else if (clr_i | fire_i) begin
      carry_q <= carry_d;
      byte_q  <= byte_d;
    end
  end

  // R6: a load leaves the carry cleared
  p_carry_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !carry_q);

  // R8: the result only moves when a byte completes
  p_byte_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_i |=> $stable(byte_q));
endmodule

// File: rtl/keystream_gen.sv
module keystream_gen
  import ksg_pkg::*;
#(
  parameter int SW = SEED_W,
  parameter int BW = BYTE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [SW-1:0] seed_i,
  input  logic [1:0]    mode_i,
  input  logic          start_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [BW-1:0] byte_o
);
  localparam int NW    = 17;
  localparam int WW    = 25;
  localparam int CNT_W = $clog2(BW);

  logic             run_q, run_d;
  logic             valid_q, valid_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  ks_mode_e         mode_q, mode_d;
  logic             adv, last;
  logic [NW-1:0]    narrow_seed;
  logic [WW-1:0]    wide_seed;
  logic [BW-1:0]    narrow_byte, wide_byte;

  assign narrow_seed = {1'b1, seed_i[15:0]};
  assign wide_seed   = {seed_i[39:19], 1'b1, seed_i[18:16]};

  assign adv  = run_q && (!valid_q || ready_i) && !load_i;
  assign last = adv && (cnt_q == CNT_W'(BW - 1));

  always_comb begin
    run_d   = run_q;
    valid_d = valid_q;
    cnt_d   = cnt_q;
    mode_d  = mode_q;
    if (load_i) begin
      run_d   = 1'b0;
      valid_d = 1'b0;
      cnt_d   = '0;
      mode_d  = ks_mode_e'(mode_i);
    end else begin
      if (start_i) run_d = 1'b1;
      if (adv) cnt_d = last ? '0 : cnt_q + 1'b1;
      if (last) valid_d = 1'b1;
      else if (valid_q && ready_i) valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      valid_q <= 1'b0;
      cnt_q   <= '0;
      mode_q  <= MODE_PLAIN;
    end else begin
      run_q   <= run_d;
      valid_q <= valid_d;
      cnt_q   <= cnt_d;
      mode_q  <= mode_d;
    end
  end

  ksg_lfsr #(.W(NW), .TAPS(17'h04001), .ONE_POS(16), .BYTE_W(BW)) u_narrow (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .seed_i(narrow_seed),
    .adv_i(adv), .col_nxt_o(narrow_byte));

  ksg_lfsr #(.W(WW), .TAPS(25'h0004019), .ONE_POS(3), .BYTE_W(BW)) u_wide (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .seed_i(wide_seed),
    .adv_i(adv), .col_nxt_o(wide_byte));

  ksg_sum #(.BYTE_W(BW)) u_sum (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(load_i), .fire_i(last),
    .narrow_i(narrow_byte), .wide_i(wide_byte),
    .inv_narrow_i(mode_q == MODE_INV_NARROW),
    .inv_wide_i(mode_q == MODE_INV_WIDE),
    .byte_o(byte_o));

  assign valid_o = valid_q;

  // R7: a load halts generation until the next start
  p_load_halts_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !run_q);

  // R9: a load drops any pending byte
  p_load_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !valid_o);

  // R8: a stalled byte stays offered and unchanged
  p_stall_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i && !load_i) |=> (valid_o && $stable(byte_o)));
endmodule

// File: tb/keystream_gen_tb.sv
module keystream_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_i = 1'b0;
  logic [39:0] seed_i = '0;
  logic [1:0]  mode_i = '0;
  logic        start_i = 1'b0;
  logic        ready_i = 1'b0;
  logic        valid_o;
  logic [7:0]  byte_o;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  bit    hold = 1'b0;
  string tag = "R6";
  logic [7:0] exp_q[$];

  always #10 clk = ~clk;

  keystream_gen dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .load_i(load_i), .seed_i(seed_i),
    .mode_i(mode_i), .start_i(start_i), .ready_i(ready_i),
    .valid_o(valid_o), .byte_o(byte_o));

  task automatic check(input bit ok, input string req, input string what,
                       input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s got %02h expected %02h", req, what, got, exp);
    end
  endtask

  // Model built from R2..R6: narrow/wide steps, LSB-first bytes, modes, carry
  task automatic push_expected(input logic [39:0] sd, input logic [1:0] md, input int n);
    logic [16:0] a;
    logic [24:0] b;
    logic [7:0]  ca, cb, x, y;
    logic [8:0]  s;
    logic        c, fa, fw;
    a = {1'b1, sd[15:0]};
    b = {sd[39:19], 1'b1, sd[18:16]};
    c = 1'b0;
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < 8; k++) begin
        fa = a[0] ^ a[14];
        fw = b[0] ^ b[3] ^ b[4] ^ b[14];
        a = {fa, a[16:1]};
        b = {fw, b[24:1]};
        ca[k] = fa;
        cb[k] = fw;
      end
      x = (md == 2'b10) ? ~ca : ca;
      y = (md == 2'b01) ? ~cb : cb;
      s = {1'b0, x} + {1'b0, y} + {8'd0, c};
      c = s[8];
      exp_q.push_back(s[7:0]);
    end
  endtask

  task automatic do_load(input logic [39:0] sd, input logic [1:0] md);
    @(negedge clk);
    load_i = 1'b1; seed_i = sd; mode_i = md;
    @(negedge clk);
    load_i = 1'b0;
    check(valid_o == 1'b0, "R9", "valid after load", {7'd0, valid_o}, 8'd0);
  endtask

  task automatic do_start();
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Monitor: choose ready for the coming edge, then score a transfer
  initial begin
    forever begin
      @(negedge clk);
      ready_i = (exp_q.size() > 0) && !hold && ($urandom_range(3) != 0);
      if (valid_o && ready_i) begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(byte_o == e, tag, "keystream byte", byte_o, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(valid_o == 1'b0, "R1", "valid in reset", {7'd0, valid_o}, 8'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check(valid_o == 1'b0, "R1", "valid after reset", {7'd0, valid_o}, 8'd0);

    // R2 R3 R4 R6: plain mode, first-byte timing then random ready
    tag = "R6";
    do_load(40'h3A_C5_96_1E_7B, 2'b00);
    push_expected(40'h3A_C5_96_1E_7B, 2'b00, 16);
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (7) @(negedge clk);
    check(valid_o == 1'b0, "R4", "valid before 8th step", {7'd0, valid_o}, 8'd0);
    @(negedge clk);
    check(valid_o == 1'b1, "R4", "valid at 8th step", {7'd0, valid_o}, 8'd1);
    drain();

    // R5: each mode code
    for (int m = 1; m < 4; m++) begin
      tag = "R5";
      do_load(40'h91_0F_E4_27_D3 + 40'(m), 2'(m));
      push_expected(40'h91_0F_E4_27_D3 + 40'(m), 2'(m), 12);
      do_start();
      drain();
    end

    // R2 R3: all-zero seed still runs from the forced bits
    tag = "R3";
    do_load(40'h0, 2'b00);
    push_expected(40'h0, 2'b00, 10);
    do_start();
    drain();

    // R7: no output without start
    do_load(40'h55_AA_55_AA_55, 2'b00);
    repeat (20) @(negedge clk);
    check(valid_o == 1'b0, "R7", "valid without start", {7'd0, valid_o}, 8'd0);

    // R8: long stall holds the first byte
    tag = "R8";
    hold = 1'b1;
    push_expected(40'h55_AA_55_AA_55, 2'b00, 6);
    do_start();
    repeat (25) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      check(valid_o == 1'b1, "R8", "valid held", {7'd0, valid_o}, 8'd1);
      check(byte_o == exp_q[0], "R8", "stalled byte", byte_o, exp_q[0]);
      @(negedge clk);
    end
    hold = 1'b0;
    drain();

    // R9 R6: reload while a byte is pending; same seed restarts with carry 0
    tag = "R9";
    do_load(40'h55_AA_55_AA_55, 2'b10);
    push_expected(40'h55_AA_55_AA_55, 2'b10, 8);
    do_start();
    drain();
    tag = "R6";
    do_load(40'h55_AA_55_AA_55, 2'b10);
    push_expected(40'h55_AA_55_AA_55, 2'b10, 8);
    do_start();
    drain();

    check(exp_q.size() == 0, "R8", "bytes outstanding", 8'(exp_q.size()), 8'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule